// File: doc/BRIEF.md
# MSI capture and interrupt aggregator

This block sits beside a PCIe-style root port and turns inbound message-signalled interrupt writes into one interrupt line towards the processor. Each inbound write arrives on a simple valid/address/data port. The block compares the 64-bit address against a programmable capture address for each of eight vector groups. On a match, the data value selects one of 32 pending bits in that group. So the global vector number is group × 32 + data.

Each group has a pending-status register, cleared by writing ones, and a per-vector enable mask. A group counts as pending only while some pending bit is also enabled. Its pending state is folded into a summary bit of a top-level status word, which also carries four sampled legacy level interrupt lines. The summary bits and legacy bits are ANDed with a top-level enable word. A two-state machine then drives the output: `IRQ_IDLE` takes the *raise* transition to `IRQ_ACTIVE` when any enabled top-level bit is set, and `IRQ_ACTIVE` takes the *settle* transition back to `IRQ_IDLE` when none is. Software reaches every register through a 32-bit register port. A read returns its data on the cycle after the read strobe.

Inbound writes that match a capture address but cannot be accepted are dropped and raise a sticky error flag. This covers a data value of 32 or more, and a group whose capture enable is off.

Top module: `msi_aggregator`

## Requirements
- R1: An inbound write whose 64-bit address equals group n's capture address, sent while group n's capture enable is on, sets bit d of group n's status (offset 0xC04 + 0x10·n) on the next clock edge. Here d is the data value, 0 to 31. The capture address is {high word at 0xC80 + 0x4·n, low word at 0xC00 + 0x10·n}.
- R2: A matching write with data of 32 or more, or to a group whose capture enable is off, changes no status bit. It sets bit 0 of the error register at 0x188. That flag stays set until a 1 is written to bit 0, and a new drop in the same cycle keeps it set.
- R3: Writing to a group status register clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. A vector that arrives in the same cycle as its clear remains set.
- R4: Bit 8+n of the top status register (0x184) becomes set only while group n has a status bit whose enable bit in the mask register (0xC08 + 0x10·n) is also 1. A pending but masked vector leaves that bit clear.
- R5: Writing 1 to bit 8+n of 0x184 clears that summary bit on the next edge. If group n is still pending, the bit is set again one edge later.
- R6: Bits 27:24 of 0x184 follow the four legacy input lines one clock edge later. Writes to these bits have no effect.
- R7: `irq_out` is 1 exactly one edge after (top status AND top enable) is non-zero, and 0 exactly one edge after it becomes zero.
- R8: After reset every register reads 0. The capture address words and the mask read back as written. The group capture-enable register (0x190) keeps only bits 7:0. The top enable register (0x180) keeps only bits 15:8 and 27:24.
- R9: An inbound write that matches no capture address is ignored: no status bit and no error flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_addr | input | 64 | Inbound message write address |
| msg_data | input | 32 | Inbound message payload (vector index) |
| intx_in | input | 4 | Legacy level interrupt lines |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_ren |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
Some rules are checked by assertions on every clock edge:
- capture of an arriving vector into its status bit, and the clear-versus-arrival ordering of each status bit;
- summary-bit clear and re-assertion;
- the one-edge tracking of the legacy lines;
- the one-edge relation between the enabled top status and `irq_out`;
- persistence of the sticky error flag.

Other behaviour only the bench scenarios can show:
- the register-map decode and the masking of the enable registers;
- drops for an oversized payload, a disabled group or a mismatched upper address word;
- the end-to-end latency from an inbound write to the interrupt line, seen through the register port.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam logic [11:0] OFS_TOP_EN   = 12'h180;
    localparam logic [11:0] OFS_TOP_STAT = 12'h184;
    localparam logic [11:0] OFS_ERR      = 12'h188;
    localparam logic [11:0] OFS_GRP_EN   = 12'h190;
    localparam logic [11:0] OFS_GRP_BASE = 12'hC00;
    localparam logic [11:0] OFS_HI_BASE  = 12'hC80;
    localparam int          SUM_LSB      = 8;
    localparam int          LEG_LSB      = 24;

    typedef enum logic [1:0] {
        SUB_ADDR_LO = 2'd0,
        SUB_STATUS  = 2'd1,
        SUB_MASK    = 2'd2,
        SUB_NONE    = 2'd3
    } grp_sub_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/msi_capture_decode.sv
module msi_capture_decode #(
    parameter int NUM_SETS    = 8,
    parameter int VEC_PER_SET = 32,
    localparam int VW         = $clog2(VEC_PER_SET),
    localparam int SW         = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                         msg_valid_i,
    input  logic [63:0]                  msg_addr_i,
    input  logic [31:0]                  msg_data_i,
    input  logic [NUM_SETS-1:0][63:0]    cap_addr_i,
    input  logic [NUM_SETS-1:0]          cap_en_i,
    output logic [NUM_SETS-1:0]          hit_o,
    output logic [VW-1:0]                vec_idx_o,
    output logic                         drop_o
);
    logic          match;
    logic [SW-1:0] sel;
    logic          accept;

    // lowest-numbered group wins when two capture addresses coincide
    always_comb begin
        match = 1'b0;
        sel   = '0;
        for (int n = NUM_SETS - 1; n >= 0; n--) begin
            if (msg_valid_i && (msg_addr_i == cap_addr_i[n])) begin
                match = 1'b1;
                sel   = SW'(n);
            end
        end
    end

    always_comb begin
        accept    = match && cap_en_i[sel] && (msg_data_i < 32'(VEC_PER_SET));
        hit_o     = '0;
        if (accept) hit_o[sel] = 1'b1;
        drop_o    = match && !accept;
        vec_idx_o = msg_data_i[VW-1:0];
    end
endmodule

// File: rtl/msi_vector_set.sv
module msi_vector_set #(
    parameter int VEC_PER_SET = 32,
    localparam int VW         = $clog2(VEC_PER_SET)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [31:0]            wdata_i,
    input  logic                   lo_we_i,
    input  logic                   hi_we_i,
    input  logic                   st_w1c_i,
    input  logic                   mask_we_i,
    input  logic                   hit_i,
    input  logic [VW-1:0]          vec_idx_i,
    output logic [63:0]            cap_addr_o,
    output logic [VEC_PER_SET-1:0] status_o,
    output logic [VEC_PER_SET-1:0] mask_o,
    output logic                   pend_o
);
    logic [31:0]            addr_lo_q, addr_hi_q;
    logic [VEC_PER_SET-1:0] status_q, mask_q;
    logic [VEC_PER_SET-1:0] clr_vec, arrive_vec;

    always_comb begin
        clr_vec    = st_w1c_i ? wdata_i[VEC_PER_SET-1:0] : '0;
        arrive_vec = hit_i ? (VEC_PER_SET'(1) << vec_idx_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            mask_q    <= '0;
            status_q  <= '0;
        end else begin
            if (lo_we_i)   addr_lo_q <= wdata_i;
            if (hi_we_i)   addr_hi_q <= wdata_i;
            if (mask_we_i) mask_q    <= wdata_i[VEC_PER_SET-1:0];
            // arrival is applied after the clear so a same-cycle event survives
            status_q <= (status_q & ~clr_vec) | arrive_vec;
        end
    end

    assign cap_addr_o = {addr_hi_q, addr_lo_q};
    assign status_o   = status_q;
    assign mask_o     = mask_q;
    assign pend_o     = |(status_q & mask_q);

    for (genvar b = 0; b < VEC_PER_SET; b++) begin : g_bit_chk
        // R1
        vec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && (vec_idx_i == VW'(b))) |=> status_q[b]);
        // R3
        vec_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_w1c_i && wdata_i[b] && !(hit_i && (vec_idx_i == VW'(b)))) |=> !status_q[b]);
        // R3
        vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!(st_w1c_i && wdata_i[b]) && !(hit_i && (vec_idx_i == VW'(b))))
            |=> (status_q[b] == $past(status_q[b])));
    end
endmodule

// File: rtl/msi_top_irq.sv
module msi_top_irq
    import msi_agg_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int NUM_LEG  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_we_i,
    input  logic [31:0]         en_wdata_i,
    input  logic                stat_we_i,
    input  logic [NUM_SETS-1:0] sum_clr_bits_i,
    input  logic [NUM_SETS-1:0] set_pend_i,
    input  logic [NUM_LEG-1:0]  leg_in_i,
    output logic [31:0]         top_en_o,
    output logic [31:0]         top_stat_o,
    output logic                irq_o
);
    localparam logic [31:0] EN_KEEP =
        ((32'(1) << NUM_SETS) - 32'd1) << SUM_LSB |
        ((32'(1) << NUM_LEG) - 32'd1) << LEG_LSB;

    logic [31:0]         en_q;
    logic [NUM_SETS-1:0] sum_q, sum_clr;
    logic [NUM_LEG-1:0]  leg_q;
    logic [31:0]         stat;
    logic                any_en;
    irq_state_e          state_q, state_d;

    assign sum_clr = stat_we_i ? sum_clr_bits_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sum_q <= '0;
            leg_q <= '0;
        end else begin
            if (en_we_i) en_q <= en_wdata_i & EN_KEEP;
            // a cleared bit comes back on the next edge while its group stays pending
            sum_q <= (sum_q | set_pend_i) & ~sum_clr;
            leg_q <= leg_in_i;
        end
    end

    always_comb begin
        stat                       = '0;
        stat[SUM_LSB +: NUM_SETS]  = sum_q;
        stat[LEG_LSB +: NUM_LEG]   = leg_q;
        any_en                     = |(stat & en_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_en)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!any_en) state_d = IRQ_IDLE;
            default:                 state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_o      = (state_q == IRQ_ACTIVE);
        top_en_o   = en_q;
        top_stat_o = stat;
    end

    for (genvar n = 0; n < NUM_SETS; n++) begin : g_sum_chk
        // R5
        sum_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_pend_i[n] && !sum_clr[n]) |=> sum_q[n]);
        // R5
        sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sum_clr[n] |=> !sum_q[n]);
    end

    // R6
    leg_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (leg_q == $past(leg_in_i)));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(top_stat_o & top_en_o)) |=> irq_o);
    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(top_stat_o & top_en_o)) |=> !irq_o);
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
    import msi_agg_pkg::*;
#(
    parameter int NUM_SETS    = 8,
    parameter int VEC_PER_SET = 32,
    parameter int NUM_LEG     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_valid,
    input  logic [63:0] msg_addr,
    input  logic [31:0] msg_data,
    input  logic [3:0]  intx_in,
    input  logic        reg_wen,
    input  logic        reg_ren,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        reg_rvalid,
    output logic        irq_out
);
    localparam int VW = $clog2(VEC_PER_SET);

    logic [NUM_SETS-1:0][63:0]          cap_addr;
    logic [NUM_SETS-1:0][VEC_PER_SET-1:0] grp_status, grp_mask;
    logic [NUM_SETS-1:0]                grp_pend, hit;
    logic [NUM_SETS-1:0]                lo_we, hi_we, st_w1c, mask_we;
    logic [VW-1:0]                      vec_idx;
    logic                               drop;
    logic [NUM_SETS-1:0]                grp_en_q;
    logic                               err_q, err_clr;
    logic [31:0]                        top_en, top_stat;
    logic [11:0]                        rel_grp, rel_hi;
    logic                               in_grp, in_hi;
    grp_sub_e                           sub;
    logic [31:0]                        rd_mux, rdata_q;
    logic                               rvalid_q;

    // register window decode
    always_comb begin
        rel_grp = reg_addr - OFS_GRP_BASE;
        rel_hi  = reg_addr - OFS_HI_BASE;
        in_grp  = (int'(rel_grp[11:4]) < NUM_SETS);
        in_hi   = (int'(rel_hi[11:2]) < NUM_SETS) && (rel_hi[1:0] == 2'b00);
        unique case (rel_grp[3:0])
            4'h0:    sub = SUB_ADDR_LO;
            4'h4:    sub = SUB_STATUS;
            4'h8:    sub = SUB_MASK;
            default: sub = SUB_NONE;
        endcase
    end

    always_comb begin
        lo_we   = '0;
        hi_we   = '0;
        st_w1c  = '0;
        mask_we = '0;
        for (int n = 0; n < NUM_SETS; n++) begin
            if (reg_wen && in_grp && (int'(rel_grp[11:4]) == n)) begin
                lo_we[n]   = (sub == SUB_ADDR_LO);
                st_w1c[n]  = (sub == SUB_STATUS);
                mask_we[n] = (sub == SUB_MASK);
            end
            if (reg_wen && in_hi && (int'(rel_hi[11:2]) == n))
                hi_we[n] = 1'b1;
        end
    end

    msi_capture_decode #(
        .NUM_SETS    (NUM_SETS),
        .VEC_PER_SET (VEC_PER_SET)
    ) u_decode (
        .msg_valid_i (msg_valid),
        .msg_addr_i  (msg_addr),
        .msg_data_i  (msg_data),
        .cap_addr_i  (cap_addr),
        .cap_en_i    (grp_en_q),
        .hit_o       (hit),
        .vec_idx_o   (vec_idx),
        .drop_o      (drop)
    );

    for (genvar n = 0; n < NUM_SETS; n++) begin : g_set
        msi_vector_set #(
            .VEC_PER_SET (VEC_PER_SET)
        ) u_set (
            .clk        (clk),
            .rst_n      (rst_n),
            .wdata_i    (reg_wdata),
            .lo_we_i    (lo_we[n]),
            .hi_we_i    (hi_we[n]),
            .st_w1c_i   (st_w1c[n]),
            .mask_we_i  (mask_we[n]),
            .hit_i      (hit[n]),
            .vec_idx_i  (vec_idx),
            .cap_addr_o (cap_addr[n]),
            .status_o   (grp_status[n]),
            .mask_o     (grp_mask[n]),
            .pend_o     (grp_pend[n])
        );
    end

    msi_top_irq #(
        .NUM_SETS (NUM_SETS),
        .NUM_LEG  (NUM_LEG)
    ) u_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_we_i        (reg_wen && (reg_addr == OFS_TOP_EN)),
        .en_wdata_i     (reg_wdata),
        .stat_we_i      (reg_wen && (reg_addr == OFS_TOP_STAT)),
        .sum_clr_bits_i (reg_wdata[SUM_LSB +: NUM_SETS]),
        .set_pend_i     (grp_pend),
        .leg_in_i       (intx_in[NUM_LEG-1:0]),
        .top_en_o       (top_en),
        .top_stat_o     (top_stat),
        .irq_o          (irq_out)
    );

    assign err_clr = reg_wen && (reg_addr == OFS_ERR) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_en_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (reg_wen && (reg_addr == OFS_GRP_EN)) grp_en_q <= reg_wdata[NUM_SETS-1:0];
            err_q <= (err_q && !err_clr) || drop;
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        if (reg_addr == OFS_TOP_EN)        rd_mux = top_en;
        else if (reg_addr == OFS_TOP_STAT) rd_mux = top_stat;
        else if (reg_addr == OFS_ERR)      rd_mux = {31'd0, err_q};
        else if (reg_addr == OFS_GRP_EN)   rd_mux = 32'(grp_en_q);
        else begin
            for (int n = 0; n < NUM_SETS; n++) begin
                if (in_grp && (int'(rel_grp[11:4]) == n)) begin
                    unique case (sub)
                        SUB_ADDR_LO: rd_mux = cap_addr[n][31:0];
                        SUB_STATUS:  rd_mux = 32'(grp_status[n]);
                        SUB_MASK:    rd_mux = 32'(grp_mask[n]);
                        SUB_NONE:    rd_mux = '0;
                        default:     rd_mux = '0;
                    endcase
                end
                if (in_hi && (int'(rel_hi[11:2]) == n)) rd_mux = cap_addr[n][63:32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_ren;
            if (reg_ren) rdata_q <= rd_mux;
        end
    end

    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !err_clr) |=> err_q);
    // R2
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_q);
endmodule

// File: tb/msi_aggregator_test.sv
module msi_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [3:0]  intx_in;
    logic        reg_wen, reg_ren;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    msi_aggregator uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr),
        .msg_data   (msg_data),
        .intx_in    (intx_in),
        .reg_wen    (reg_wen),
        .reg_ren    (reg_ren),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_out    (irq_out)
    );

    function automatic logic [63:0] grp_addr(input int n);
        return {32'h0000_0001 + 32'(n), 32'hFEED_0000 + 32'(n * 16)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares each returned read with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                check("unexpected read data", reg_rdata, 32'hDEAD_BEEF);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_expect(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_ren = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_ren = 1'b0;
    endtask

    task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = a; msg_data = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; msg_valid = 1'b0; msg_addr = '0; msg_data = '0;
        intx_in = '0; reg_wen = 1'b0; reg_ren = 1'b0; reg_addr = '0; reg_wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R8 reset state
        check("R8 irq after reset", 32'(irq_out), 32'd0);
        reg_expect(12'h184, 32'h0, "R8 reset top status");
        reg_expect(12'h180, 32'h0, "R8 reset top enable");
        reg_expect(12'h188, 32'h0, "R8 reset error flag");
        reg_expect(12'hC04, 32'h0, "R8 reset group0 status");

        // programme capture addresses, enables, masks
        for (int n = 0; n < 8; n++) begin
            reg_write(12'hC00 + 12'(n * 16), grp_addr(n)[31:0]);
            reg_write(12'hC80 + 12'(n * 4), grp_addr(n)[63:32]);
        end
        reg_write(12'h190, 32'hFFFF_FFFF);
        reg_write(12'h180, 32'hFFFF_FFFF);
        reg_write(12'hC28, 32'hFFFF_FFFF);
        reg_expect(12'hC30, 32'hFEED_0030, "R8 group3 low address");
        reg_expect(12'hC8C, 32'h0000_0004, "R8 group3 high address");
        reg_expect(12'h190, 32'h0000_00FF, "R8 group enable width");
        reg_expect(12'h180, 32'h0F00_FF00, "R8 top enable kept bits");
        reg_expect(12'hC28, 32'hFFFF_FFFF, "R8 group2 mask");

        // R1 capture and R7 rise timing
        send_msg(grp_addr(2), 32'd5);
        check("R7 irq low one edge after capture", 32'(irq_out), 32'd0);
        idle(1);
        check("R7 irq low while summary registers", 32'(irq_out), 32'd0);
        idle(1);
        check("R7 irq high one edge after summary", 32'(irq_out), 32'd1);
        reg_expect(12'hC24, 32'h0000_0020, "R1 group2 vector5");
        reg_expect(12'h184, 32'h0000_0400, "R4 group2 summary");

        // R4 masked vector does not reach the summary
        send_msg(grp_addr(4), 32'd7);
        idle(2);
        reg_expect(12'hC44, 32'h0000_0080, "R1 group4 vector7 captured");
        reg_expect(12'h184, 32'h0000_0400, "R4 masked group4 no summary");

        // R2 oversized payload
        send_msg(grp_addr(1), 32'd40);
        reg_expect(12'hC14, 32'h0, "R2 oversized payload dropped");
        reg_expect(12'h188, 32'h1, "R2 error flag set");
        reg_write(12'h188, 32'h0);
        reg_expect(12'h188, 32'h1, "R2 error flag ignores zero");
        reg_write(12'h188, 32'h1);
        reg_expect(12'h188, 32'h0, "R2 error flag cleared");

        // R2 disabled group
        reg_write(12'h190, 32'h0000_00BF);
        send_msg(grp_addr(6), 32'd3);
        reg_expect(12'hC64, 32'h0, "R2 disabled group dropped");
        reg_expect(12'h188, 32'h1, "R2 error flag on disabled group");
        reg_write(12'h188, 32'h1);

        // R9 mismatched upper address word
        send_msg({32'h0000_0099, grp_addr(0)[31:0]}, 32'd1);
        reg_expect(12'hC04, 32'h0, "R9 mismatch no status");
        reg_expect(12'h188, 32'h0, "R9 mismatch no error");

        // R5 summary re-asserts while group still pending
        reg_write(12'h184, 32'h0000_0400);
        idle(1);
        reg_expect(12'h184, 32'h0000_0400, "R5 summary reasserted");

        // R3 zero write keeps, one write clears
        reg_write(12'hC24, 32'h0);
        reg_expect(12'hC24, 32'h0000_0020, "R3 zero write no effect");
        reg_write(12'hC24, 32'h0000_0020);
        reg_expect(12'hC24, 32'h0, "R3 one write clears");

        // R7 fall timing after clearing the summary
        idle(2);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = 12'h184; reg_wdata = 32'h0000_0400;
        @(negedge clk);
        reg_wen = 1'b0;
        check("R7 irq still high at clear edge", 32'(irq_out), 32'd1);
        @(negedge clk);
        check("R7 irq low one edge later", 32'(irq_out), 32'd0);
        reg_expect(12'h184, 32'h0, "R5 summary stays clear when idle");

        // R3 arrival in the same cycle as its clear
        @(negedge clk);
        msg_valid = 1'b1; msg_addr = grp_addr(2); msg_data = 32'd9;
        reg_wen = 1'b1; reg_addr = 12'hC24; reg_wdata = 32'h0000_0200;
        @(negedge clk);
        msg_valid = 1'b0; reg_wen = 1'b0;
        reg_expect(12'hC24, 32'h0000_0200, "R3 same-cycle arrival survives");

        // R6 legacy lines
        intx_in = 4'b0100;
        idle(2);
        reg_expect(12'h184, 32'h0400_0400, "R6 legacy line sampled");
        reg_write(12'h184, 32'h0400_0000);
        reg_expect(12'h184, 32'h0400_0400, "R6 legacy bit ignores clear");
        intx_in = 4'b0000;
        idle(2);
        reg_expect(12'h184, 32'h0000_0400, "R6 legacy line released");

        idle(3);
        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule